// File: doc/BRIEF.md
# Serial Link Training Transmit Sequencer

This block drives a 10-bit parallel-to-serial line transmitter. It runs on the serial bit clock. Each 12 clock cycles make one frame time, which is one period of the parallel word clock. Before anything happens on the line, the block waits for the local PLL to report lock. It then sends frames continuously, one after another. Each frame is one of two kinds. A data frame carries the parallel word between a start bit and a stop bit. A training frame is a fixed half-ones, half-zeros pattern that lets a far-end receiver acquire the embedded clock.

Either of two sync request inputs switches the stream to training. Training lasts for a minimum number of frames (1024 by default). After that minimum it continues for as long as a request is still present. The stream only ever changes between frame kinds at a frame boundary. Power-down and loss of lock put the block back into its idle initial state. A separate output enable gates only the line driver.

Top module: `lnk_sync_tx`

## Requirements
- R1: After reset and while `pll_lock` is low, `drv_en`, `ser_bit` and `frame_start` stay low.
- R2: Once `pll_lock` is high (and `pwr_dn` low), a frame begins on the first clock and then every 12 clocks. `frame_start` is high only during the first bit of each frame, and that first bit is always 1.
- R3: A data frame is sent as bit 1, then `word_in` bits 0 to 9 (LSB first), then bit 0. `word_in` is sampled on the clock edge where `frame_start` rises.
- R4: A training frame is six 1 bits followed by six 0 bits.
- R5: If `sync_a` or `sync_b` is high on any clock edge within a frame, or on the edge that starts the next frame, the next frame is a training frame.
- R6: Training that starts from data (or from idle) lasts at least 1024 frames, even if the request was only one clock long. When no request is seen during those frames, it lasts exactly 1024 frames.
- R7: After the minimum, another training frame follows each frame during which a request was seen.
- R8: The frame kind changes only at a frame boundary. Every frame is complete, and the first data frame after training carries the word sampled at its start.
- R9: `pwr_dn` forces `drv_en`, `ser_bit` and `frame_start` low on the next clock and clears the training minimum. After release with no request, the first frame is a data frame.
- R10: When `out_en` is low, `drv_en` goes low on the next clock, but frames continue to be formed and sent as usual.
- R11: While locked and not powered down, `drv_en` equals the value `out_en` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (12 per word clock) |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock | input | 1 | Local PLL lock indication |
| pwr_dn | input | 1 | Power-down request |
| out_en | input | 1 | Line driver enable request |
| sync_a | input | 1 | Training request, first source |
| sync_b | input | 1 | Training request, second source |
| word_in | input | 10 | Parallel data word |
| frame_start | output | 1 | High during the first bit of each frame |
| ser_bit | output | 1 | Serial bit stream |
| drv_en | output | 1 | Line driver enable (low = tri-state) |

## Verification
Several properties are checked on every clock cycle: the outputs stay quiet when unlocked or powered down, the start bit is always high and the stop bit always low, the frame kind only changes at a boundary, a pending minimum count always implies training, and `drv_en` tracks `out_en` with a one-clock delay. Other behaviour can only be shown by the bench's scenarios. These include the exact bit order of data frames for specific words, the exact 1024-frame length after a one-clock request, the extension while a request is held, and the return to data after power-down.

// File: rtl/lst_pkg.sv
package lst_pkg;

  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_DATA  = 2'd1,
    LS_TRAIN = 2'd2
  } link_st_e;

  // Training frame: lower half ones (sent first), upper half zeros.
  function automatic logic [63:0] train_bits(input int unsigned frame_w);
    logic [63:0] v;
    v = '0;
    for (int unsigned i = 0; i < frame_w / 2; i++) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/lst_bit_timer.sv
module lst_bit_timer #(
  parameter int FRAME_W = 12,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic load,
  output logic active
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic             act_q;

  assign load   = run & (~act_q | (idx_q == LAST_IDX));
  assign active = act_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      idx_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= 1'b1;
      if (load) idx_q <= '0;
      else      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/lst_train_ctrl.sv
module lst_train_ctrl
  import lst_pkg::*;
#(
  parameter int TRAIN_MIN = 1024,
  localparam int CNT_W    = $clog2(TRAIN_MIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic             sync_a,
  input  logic             sync_b,
  output logic             train_now,
  output logic             in_train,
  output logic [CNT_W-1:0] left_q
);

  localparam logic [CNT_W-1:0] FIRST_LEFT = CNT_W'(TRAIN_MIN - 1);

  link_st_e st_q;
  logic     seen_q;
  logic     req;

  assign in_train = (st_q == LS_TRAIN);

  always_comb begin
    req       = sync_a | sync_b | seen_q;
    train_now = req | (in_train & (left_q != '0));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st_q   <= LS_IDLE;
      left_q <= '0;
      seen_q <= 1'b0;
    end else if (load) begin
      seen_q <= 1'b0;
      st_q   <= train_now ? LS_TRAIN : LS_DATA;
      if (train_now) begin
        if (!in_train)            left_q <= FIRST_LEFT;
        else if (left_q != '0)    left_q <= left_q - 1'b1;
      end
    end else begin
      seen_q <= seen_q | sync_a | sync_b;
    end
  end

endmodule

// File: rtl/lst_frame_shift.sv
module lst_frame_shift
  import lst_pkg::*;
#(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic              train_now,
  input  logic [DATA_W-1:0] word_in,
  output logic              ser_bit,
  output logic              frame_start
);

  localparam logic [63:0]        TRAIN_ALL = train_bits(FRAME_W);
  localparam logic [FRAME_W-1:0] TRAIN_PAT = TRAIN_ALL[FRAME_W-1:0];

  logic [FRAME_W-1:0] sh_q;
  logic               fs_q;
  logic [FRAME_W-1:0] data_frame;

  assign data_frame  = {1'b0, word_in, 1'b1};
  assign ser_bit     = sh_q[0];
  assign frame_start = fs_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sh_q <= '0;
      fs_q <= 1'b0;
    end else if (load) begin
      sh_q <= train_now ? TRAIN_PAT : data_frame;
      fs_q <= 1'b1;
    end else begin
      sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
      fs_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lnk_sync_tx.sv
module lnk_sync_tx #(
  parameter int DATA_W    = 10,
  parameter int TRAIN_MIN = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_lock,
  input  logic              pwr_dn,
  input  logic              out_en,
  input  logic              sync_a,
  input  logic              sync_b,
  input  logic [DATA_W-1:0] word_in,
  output logic              frame_start,
  output logic              ser_bit,
  output logic              drv_en
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(TRAIN_MIN + 1);

  logic             run;
  logic             load;
  logic             frm_act;
  logic             train_now;
  logic             trn_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drv_q;

  assign run    = pll_lock & ~pwr_dn;
  assign drv_en = drv_q;

  lst_bit_timer #(.FRAME_W(FRAME_W)) u_tim (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .load   (load),
    .active (frm_act)
  );

  lst_train_ctrl #(.TRAIN_MIN(TRAIN_MIN)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .load      (load),
    .sync_a    (sync_a),
    .sync_b    (sync_b),
    .train_now (train_now),
    .in_train  (trn_q),
    .left_q    (cnt_q)
  );

  lst_frame_shift #(.DATA_W(DATA_W)) u_shf (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .load        (load),
    .train_now   (train_now),
    .word_in     (word_in),
    .ser_bit     (ser_bit),
    .frame_start (frame_start)
  );

  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else     drv_q <= run & out_en;
  end

endmodule

// File: rtl/lnk_sync_tx_chk.sv
module lnk_sync_tx_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          pll_lock,
  input logic          pwr_dn,
  input logic          out_en,
  input logic          frame_start,
  input logic          ser_bit,
  input logic          drv_en,
  input logic          load,
  input logic          frm_act,
  input logic          trn_q,
  input logic [CW-1:0] cnt_q
);

  a_r1_unlocked_quiet: assert property (@(posedge clk) disable iff (rst)
    !pll_lock |=> (!drv_en && !ser_bit && !frame_start));

  a_r9_pwrdn_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!drv_en && !ser_bit && !frame_start && cnt_q == '0));

  a_r2_start_bit_high: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ser_bit);

  a_r2_start_isolated: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r3_stop_bit_low: assert property (@(posedge clk) disable iff (rst)
    (frame_start && $past(frm_act)) |-> !$past(ser_bit));

  a_r8_kind_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (pll_lock && !pwr_dn && !load) |=> $stable(trn_q));

  a_r6_min_implies_train: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> trn_q);

  a_r11_drv_follows_oe: assert property (@(posedge clk) disable iff (rst)
    (pll_lock && !pwr_dn) |=> (drv_en == $past(out_en)));

endmodule

bind lnk_sync_tx lnk_sync_tx_chk #(.CW(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pll_lock    (pll_lock),
  .pwr_dn      (pwr_dn),
  .out_en      (out_en),
  .frame_start (frame_start),
  .ser_bit     (ser_bit),
  .drv_en      (drv_en),
  .load        (load),
  .frm_act     (frm_act),
  .trn_q       (trn_q),
  .cnt_q       (cnt_q)
);

// File: tb/lnk_sync_tx_bench.sv
`timescale 1ns/1ps
module lnk_sync_tx_bench;

  localparam logic [11:0] TRAIN_F = 12'h03F;
  // {word, expected frame}
  localparam logic [21:0] VEC [8] = '{
    {10'h000, 12'h001}, {10'h3FF, 12'h7FF}, {10'h155, 12'h2AB}, {10'h2AA, 12'h555},
    {10'h001, 12'h003}, {10'h200, 12'h401}, {10'h0F0, 12'h1E1}, {10'h30C, 12'h619}
  };

  logic       clk = 1'b0;
  logic       rst, pll_lock, pwr_dn, out_en, sync_a, sync_b;
  logic [9:0] word_in;
  logic       frame_start, ser_bit, drv_en;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  lnk_sync_tx u_lnk_sync_tx (
    .clk(clk), .rst(rst), .pll_lock(pll_lock), .pwr_dn(pwr_dn), .out_en(out_en),
    .sync_a(sync_a), .sync_b(sync_b), .word_in(word_in),
    .frame_start(frame_start), .ser_bit(ser_bit), .drv_en(drv_en)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic grab_here(output logic [11:0] f);
    f[0] = ser_bit;
    for (int i = 1; i < 12; i++) begin
      @(negedge clk);
      f[i] = ser_bit;
    end
  endtask

  task automatic get_frame(output logic [11:0] f, output int waits);
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!frame_start && waits < 40);
    grab_here(f);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] f;
    int          w;
    int          n;
    logic        quiet;
    rst = 1'b1; pll_lock = 1'b0; pwr_dn = 1'b0; out_en = 1'b1;
    sync_a = 1'b0; sync_b = 1'b0; word_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    quiet = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (drv_en || ser_bit || frame_start) quiet = 1'b0;
    end
    chk(quiet, "R1 quiet while unlocked", {drv_en, ser_bit, frame_start}, 0);

    pll_lock = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b1, "R11 drv_en after lock", drv_en, 1);
    chk(frame_start && ser_bit, "R2 first frame start bit", {frame_start, ser_bit}, 3);
    get_frame(f, w);
    chk(w == 12, "R2 frame spacing 12", w, 12);

    // Table of data words
    for (int i = 0; i < 8; i++) begin
      word_in = VEC[i][21:12];
      get_frame(f, w);
      chk(f == VEC[i][11:0], "R3 data frame bits", f, VEC[i][11:0]);
      chk(w == 1, "R2 back-to-back frames", w, 1);
    end

    // One-clock sync pulse mid frame
    @(negedge clk);
    @(negedge clk); sync_a = 1'b1;
    @(negedge clk); sync_a = 1'b0;
    get_frame(f, w);
    chk(f == TRAIN_F, "R5 training after one-clock request", f, TRAIN_F);
    chk(f == TRAIN_F, "R4 training pattern", f, TRAIN_F);
    n = 1;
    while (n < 1100) begin
      get_frame(f, w);
      if (f != TRAIN_F) break;
      n++;
    end
    chk(n == 1024, "R6 minimum training length", n, 1024);
    chk(f == 12'h619, "R8 first data frame after training", f, 12'h619);

    // Held request extends training
    sync_b = 1'b1;
    n = 0;
    for (int i = 0; i < 1040; i++) begin
      get_frame(f, w);
      if (f == TRAIN_F) n++;
    end
    chk(n == 1040, "R7 training while request held", n, 1040);
    sync_b = 1'b0;
    get_frame(f, w);
    chk(f == TRAIN_F, "R7 trailing frame for request seen", f, TRAIN_F);
    get_frame(f, w);
    chk(f == 12'h619, "R8 data after held request", f, 12'h619);

    // Power-down during training
    sync_a = 1'b1;
    @(negedge clk); sync_a = 1'b0;
    for (int i = 0; i < 3; i++) get_frame(f, w);
    chk(f == TRAIN_F, "R5 training before power-down", f, TRAIN_F);
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk);
    chk(!drv_en && !ser_bit && !frame_start, "R9 outputs quiet in power-down",
        {drv_en, ser_bit, frame_start}, 0);
    quiet = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (drv_en || frame_start) quiet = 1'b0;
    end
    chk(quiet, "R9 stays quiet", {drv_en, frame_start}, 0);
    word_in = 10'h2C3;
    pwr_dn = 1'b0;
    @(negedge clk);
    chk(frame_start == 1'b1, "R9 frame restarts on release", frame_start, 1);
    grab_here(f);
    chk(f == 12'h587, "R9 data frame after release", f, 12'h587);

    // Output enable gating
    @(negedge clk); @(negedge clk);
    out_en = 1'b0; word_in = 10'h1A5;
    @(negedge clk);
    chk(drv_en == 1'b0, "R10 drv_en low after out_en low", drv_en, 0);
    get_frame(f, w);
    chk(f == 12'h34B, "R10 frames continue while disabled", f, 12'h34B);
    out_en = 1'b1;
    @(negedge clk);
    chk(drv_en == 1'b1, "R11 drv_en returns", drv_en, 1);

    // Lock loss
    pll_lock = 1'b0;
    @(negedge clk);
    chk(!drv_en && !ser_bit && !frame_start, "R1 quiet after lock loss",
        {drv_en, ser_bit, frame_start}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule